// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital state machine that runs the conversion cycle of a serial sampling converter. It takes an active-low chip select, a conversion-start strobe, a power-down pin and a supply-ready flag. It walks through power-up, idle, sampling, conversion and low-power phases, and it drives a BUSY flag while a conversion is in flight. The analog conversion is modelled as a fixed number of clock cycles. Each completed conversion returns a stand-in result word.

The start strobe is only seen through a qualifying stage. This stage copies the strobe while chip select is low and holds it while chip select is high. The qualified level is synchronized and edge-detected on the system clock. A falling edge of the qualified strobe starts a conversion. The same edge arriving during a conversion aborts it. A qualified start that is still high when a conversion finishes chains straight into the next sampling phase. A long idle time after a conversion drops the block into a nap phase.

Top module: `adc_conv_seq`

## Requirements
- R1: While `csN` is high, changes on `convStart` are ignored: the qualified start level keeps its last value, so the state does not leave wait, and a held high level keeps the block in sample.
- R2: After reset the block stays in power-on (`seqState` = 0, `busy` = 0) until `supplyOk` is 1 and `pwrDown` is 0. It then moves to wait (`seqState` = 1).
- R3: In wait, a qualified start level of 1 moves the block to sample (`seqState` = 2) with `busy` = 0.
- R4: In sample, a falling edge of the qualified start raises `busy` through start-of-conversion (`seqState` = 3) and conversion (`seqState` = 4). `busy` stays high for exactly CONV_CYCLES+1 clock cycles.
- R5: When a conversion completes, `busy` falls in the same cycle that `resultValid` rises. `resultValid` is high for one cycle only. `resultData` goes up by one for each completed conversion, so the first result after reset is 1.
- R6: A falling edge of the qualified start while converting moves the block to abort (`seqState` = 7) with `busy` = 0. No `resultValid` pulse is produced. The block then returns to wait if the qualified start is low, and to sample if it is high.
- R7: In end-of-conversion (`seqState` = 5), a qualified start level of 1 moves the block directly to sample on the next cycle (back-to-back operation).
- R8: If the block spends NAP_IDLE cycles in end-of-conversion without a qualified start, it enters nap (`seqState` = 6) with `busy` = 0.
- R9: In nap, a qualified start level of 1 moves the block to sample.
- R10: A synchronous active-high `rst` forces power-on, with `busy`, `resultValid` and `resultData` all 0. This holds even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low; qualifies the start strobe |
| convStart | input | 1 | Conversion start strobe |
| pwrDown | input | 1 | Power-down request; holds the block in power-on |
| supplyOk | input | 1 | Supplies are inside their operating range |
| busy | output | 1 | High during start-of-conversion and conversion |
| resultValid | output | 1 | One-cycle pulse when a conversion completes |
| resultData | output | RESULT_W (16) | Stand-in conversion result |
| seqState | output | 3 | Current phase code, as listed in the requirements |

## Verification
The bench toggles the start strobe while chip select is high. A design that let the strobe through would start sampling or lose the held level. The bench counts BUSY width cycle by cycle, where an off-by-one counter shows up as 12 or 14 instead of 13. It also checks that the result pulse lines up with the BUSY fall. The bench aborts a conversion with a second falling edge and counts result pulses. A design that ignored the edge, or that latched a result on abort, would show an extra pulse or a later increment of the result. Finally, the bench drives a back-to-back start, lets an idle gap run into nap, and applies reset mid-conversion. These catch a wrong exit from end-of-conversion, a wrong idle count, or a reset that leaves BUSY set.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRON  = 3'd0,
    ST_WAIT   = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_SOC    = 3'd3,
    ST_CONV   = 3'd4,
    ST_EOC    = 3'd5,
    ST_NAP    = 3'd6,
    ST_ABORT  = 3'd7
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrConv;
    logic runConv;
    logic clrIdle;
    logic runIdle;
    logic latchResult;
  } seqCtrl_t;

endpackage

// File: rtl/adc_conv_seq_datapath.sv
module adc_conv_seq_datapath
  import adc_conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 18,
  parameter int NAP_IDLE    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int RESULT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csN,
  input  logic                convStart,
  input  seqCtrl_t            ctrl,
  output logic                qualHigh,
  output logic                qualFall,
  output logic                convDone,
  output logic                idleDone,
  output logic                resultValid,
  output logic [RESULT_W-1:0] resultData
);

  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int IW = $clog2(NAP_IDLE + 1);

  logic                   qualLatch;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   qualPrev;
  logic [CW-1:0]          convCnt;
  logic [IW-1:0]          idleCnt;

  // qualifying stage: follows the strobe only while chip select is low
  always_ff @(posedge clk) begin
    if (rst)        qualLatch <= 1'b0;
    else if (!csN)  qualLatch <= convStart;
  end

  // synchronizer chain, one flop per stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= qualLatch;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) syncChain[s] <= 1'b0;
          else     syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) qualPrev <= 1'b0;
    else     qualPrev <= syncChain[SYNC_STAGES-1];
  end

  assign qualHigh = syncChain[SYNC_STAGES-1];
  assign qualFall = qualPrev & ~syncChain[SYNC_STAGES-1];

  // conversion length counter
  always_ff @(posedge clk) begin
    if (rst || ctrl.clrConv) convCnt <= '0;
    else if (ctrl.runConv)   convCnt <= convCnt + 1'b1;
  end
  assign convDone = (convCnt == CW'(CONV_CYCLES - 1));

  // idle counter after end of conversion
  always_ff @(posedge clk) begin
    if (rst || ctrl.clrIdle) idleCnt <= '0;
    else if (ctrl.runIdle)   idleCnt <= idleCnt + 1'b1;
  end
  assign idleDone = (idleCnt == IW'(NAP_IDLE - 1));

  // stand-in result: running count of completed conversions
  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= ctrl.latchResult;
      if (ctrl.latchResult) resultData <= resultData + 1'b1;
    end
  end

  a_r1_qual_hold: assert property (@(posedge clk) disable iff (rst)
    csN |=> $stable(qualLatch));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  a_r5_data_step: assert property (@(posedge clk) disable iff (rst)
    ctrl.latchResult |=> resultData == $past(resultData) + RESULT_W'(1));

endmodule

// File: rtl/adc_conv_seq_control.sv
module adc_conv_seq_control
  import adc_conv_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwrDown,
  input  logic      supplyOk,
  input  logic      qualHigh,
  input  logic      qualFall,
  input  logic      convDone,
  input  logic      idleDone,
  output seqCtrl_t  ctrl,
  output logic      busy,
  output seqState_t state
);

  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PWRON;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PWRON:  if (supplyOk && !pwrDown) nextState = ST_WAIT;
      ST_WAIT:   if (qualHigh) nextState = ST_SAMPLE;
      ST_SAMPLE: if (qualFall) nextState = ST_SOC;
      ST_SOC:    nextState = ST_CONV;
      ST_CONV: begin
        if (qualFall)      nextState = ST_ABORT;
        else if (convDone) nextState = ST_EOC;
      end
      ST_EOC: begin
        if (qualHigh)      nextState = ST_SAMPLE;
        else if (idleDone) nextState = ST_NAP;
      end
      ST_NAP:    if (qualHigh) nextState = ST_SAMPLE;
      ST_ABORT:  nextState = qualHigh ? ST_SAMPLE : ST_WAIT;
      default:   nextState = ST_PWRON;
    endcase
  end

  always_comb begin
    ctrl             = '0;
    ctrl.clrConv     = (state == ST_SOC);
    ctrl.runConv     = (state == ST_CONV);
    ctrl.latchResult = (state == ST_CONV) && !qualFall && convDone;
    ctrl.clrIdle     = ctrl.latchResult;
    ctrl.runIdle     = (state == ST_EOC);
  end

  assign busy = (state == ST_SOC) || (state == ST_CONV);

  a_r2_pwron_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWRON && (pwrDown || !supplyOk)) |=> state == ST_PWRON);

  a_r4_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE && qualFall) |=> busy);

  a_r6_abort: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && qualFall) |=> (state == ST_ABORT && !busy));

  a_r7_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EOC && qualHigh) |=> state == ST_SAMPLE);

  a_r8_nap_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EOC && idleDone && !qualHigh) |=> state == ST_NAP);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 18,
  parameter int NAP_IDLE    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int RESULT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csN,
  input  logic                convStart,
  input  logic                pwrDown,
  input  logic                supplyOk,
  output logic                busy,
  output logic                resultValid,
  output logic [RESULT_W-1:0] resultData,
  output logic [2:0]          seqState
);

  seqCtrl_t  ctrl;
  seqState_t state;
  logic      qualHigh, qualFall, convDone, idleDone;

  adc_conv_seq_datapath #(
    .CONV_CYCLES(CONV_CYCLES),
    .NAP_IDLE   (NAP_IDLE),
    .SYNC_STAGES(SYNC_STAGES),
    .RESULT_W   (RESULT_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .csN        (csN),
    .convStart  (convStart),
    .ctrl       (ctrl),
    .qualHigh   (qualHigh),
    .qualFall   (qualFall),
    .convDone   (convDone),
    .idleDone   (idleDone),
    .resultValid(resultValid),
    .resultData (resultData)
  );

  adc_conv_seq_control ctl_i (
    .clk      (clk),
    .rst      (rst),
    .pwrDown  (pwrDown),
    .supplyOk (supplyOk),
    .qualHigh (qualHigh),
    .qualFall (qualFall),
    .convDone (convDone),
    .idleDone (idleDone),
    .ctrl     (ctrl),
    .busy     (busy),
    .state    (state)
  );

  assign seqState = state;

endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_N     = 12;
  localparam int IDLE_M     = 10;
  localparam int NV         = 13;

  typedef struct packed {
    logic       csN;
    logic       st;
    logic       pd;
    logic       ok;
    logic [7:0] hold;
    logic [2:0] expState;
    logic       expBusy;
  } vec_t;

  // csN, start, pwrDown, supplyOk, hold cycles, expected state, expected busy
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd4,  3'd0, 1'b0},  // R2 held by pwrDown
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  3'd0, 1'b0},  // R2 held by supply
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd3,  3'd1, 1'b0},  // R2 leave to wait
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd6,  3'd1, 1'b0},  // R1 start ignored
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd6,  3'd2, 1'b0},  // R3 wait to sample
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd6,  3'd4, 1'b1},  // R4 converting
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd14, 3'd5, 1'b0},  // R5 end of conversion
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 3'd6, 1'b0},  // R8 nap
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd6,  3'd2, 1'b0},  // R9 nap to sample
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'd6,  3'd2, 1'b0},  // R1 held high
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd6,  3'd4, 1'b1},  // R4 second conversion
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd2,  3'd4, 1'b1},  // R6 rise mid conversion
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd6,  3'd1, 1'b0}   // R6 abort back to wait
  };

  function automatic string rowTag(int i);
    case (i)
      0, 1, 2:  return "R2";
      3, 9:     return "R1";
      4:        return "R3";
      5, 10:    return "R4";
      6:        return "R5";
      7:        return "R8";
      8:        return "R9";
      default:  return "R6";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csN = 1'b1;
  logic        convStart = 1'b0;
  logic        pwrDown = 1'b1;
  logic        supplyOk = 1'b1;
  logic        busy;
  logic        resultValid;
  logic [15:0] resultData;
  logic [2:0]  seqState;

  int total = 0;
  int bad = 0;
  int rvSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq #(
    .CONV_CYCLES(CONV_N),
    .NAP_IDLE   (IDLE_M),
    .SYNC_STAGES(2),
    .RESULT_W   (16)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .csN        (csN),
    .convStart  (convStart),
    .pwrDown    (pwrDown),
    .supplyOk   (supplyOk),
    .busy       (busy),
    .resultValid(resultValid),
    .resultData (resultData),
    .seqState   (seqState)
  );

  always @(negedge clk) if (!rst && resultValid) rvSeen++;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10", "state", seqState, 0);
    chk("R10", "busy", busy, 0);
    chk("R10", "valid", resultValid, 0);
    chk("R10", "data", resultData, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      csN = VECS[i].csN;
      convStart = VECS[i].st;
      pwrDown = VECS[i].pd;
      supplyOk = VECS[i].ok;
      repeat (int'(VECS[i].hold)) @(negedge clk);
      chk(rowTag(i), "state", seqState, int'(VECS[i].expState));
      chk(rowTag(i), "busy", busy, int'(VECS[i].expBusy));
    end

    // R6: the aborted conversion made no pulse; only the first one did
    chk("R6", "valid pulses", rvSeen, 1);
    chk("R5", "first result", resultData, 1);

    // R4 busy width, R5 pulse alignment, R7 back-to-back
    convStart = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3", "state", seqState, 2);
    convStart = 1'b0;
    cnt = 0;
    while (!busy && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    cnt = 0;
    while (busy && cnt < 40) begin
      cnt++;
      if (cnt == 3) convStart = 1'b1;
      @(negedge clk);
    end
    chk("R4", "busy cycles", cnt, CONV_N + 1);
    chk("R5", "valid at busy fall", resultValid, 1);
    chk("R5", "result", resultData, 2);
    chk("R7", "eoc state", seqState, 5);
    @(negedge clk);
    chk("R5", "valid one cycle", resultValid, 0);
    chk("R7", "back-to-back state", seqState, 2);

    // R10 reset in the middle of a conversion
    convStart = 1'b0;
    repeat (7) @(negedge clk);
    chk("R4", "busy before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "state", seqState, 0);
    chk("R10", "busy", busy, 0);
    chk("R10", "valid", resultValid, 0);
    chk("R10", "data", resultData, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule